// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block is a cluster of small control registers reached over a simple single-cycle peripheral bus. The upper address bits pick one of seven regions. Each region holds one register: a configuration byte, a diagnostic byte, a modem-control byte, two auxiliary bytes, a 16-bit LED word and a 32-bit system-control word. Every region requires one exact access width. An access with the wrong width or offset writes nothing, reads zero and raises an error pulse.

Four outputs leave the block:

- a level power-fail interrupt;
- a floppy terminal-count strobe;
- a power-off request;
- a system-reset request.

The strobes and requests are one-cycle pulses launched from the write that causes them. The asynchronous power-failing input passes through a synchronizer. Each change of the synchronized level re-evaluates the latched power-fail flag against the enable bit in the configuration register.

Top module: `auxctl_top`

Addressing is `bus_addr = {region[2:0], offset[2:0]}`. The region codes are: configuration 0, diagnostic 1, modem 2, LED 3, system control 4, aux1 5 and aux2 6. Code 7 is unused. The `bus_size` codes are: 0 for a byte, 1 for a half word, 2 for a word. Code 3 is never legal.

## Requirements
- R1: `pf_irq` is high exactly when aux2 bit 5 (power-fail flag) and configuration bit 3 (power interrupt enable) are both set. It follows configuration writes in the cycle after the write.
- R2: A change of the synchronized `pwr_failing` level sets aux2 bit 5 when that level is 1 and configuration bit 3 is set. It clears bit 5 when the level is 0 or the enable is clear. The flag updates SYNC_STAGES+1 clock edges after the input changes.
- R3: An aux2 write keeps only data bits 0 and 1. Bit 1 set clears the power-fail flag. Aux2 reads back bit 0 as written, bit 5 as the flag and every other bit, bit 1 included, as 0.
- R4: An aux2 write with data bit 0 set drives `pwroff_req` high for one cycle, the cycle after the write edge.
- R5: An aux1 write with data bit 1 set drives `tc_pulse` high for one cycle, the cycle after the write edge. Aux1 stores the other bits as written and bit 1 always reads 0.
- R6: A word write to system control at offset 0 with data bit 0 set makes the register read 0x00000002 and pulses `sysrst_req` for one cycle. A write with bit 0 clear, or at offset 4, does nothing. A word read at offset 4 returns 0.
- R7: Reset clears configuration, aux1, aux2 and modem control. Diagnostic, LED and system-control contents survive reset.
- R8: Each region has one legal access:
  - the byte registers take only byte accesses at offset 0;
  - the LED register takes only half-word accesses at offset 0;
  - system control takes only word accesses at offset 0 or 4.

  Any other access writes nothing, reads 0 and raises `bus_err` for the one cycle after it.
- R9: Configuration, diagnostic, modem and LED registers read back the last value written.
- R10: Each request or strobe pulse drops again in the cycle after it rose, when no new triggering write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe for the current cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | {region code, byte offset} |
| bus_size | input | 2 | Access width code: 0 byte, 1 half word, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational in the access cycle |
| bus_err | output | 1 | One-cycle pulse after an illegal access |
| pwr_failing | input | 1 | Asynchronous power-failing indication |
| pf_irq | output | 1 | Level power-fail interrupt |
| tc_pulse | output | 1 | Floppy terminal-count strobe |
| pwroff_req | output | 1 | Power-off request pulse |
| sysrst_req | output | 1 | System-reset request pulse |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2. This shows that the power-fail flag waits for the whole synchronizer chain plus the change detector. The waits in the bench are derived from that parameter and are not fixed.

The other parameters keep their defaults. This puts the offset-4 system-control word, the half-word LED register and the unused region code at addresses the bench can reach directly.

// File: rtl/auxctl_pkg.sv
package auxctl_pkg;

   typedef enum logic [2:0] {
      RG_CFG   = 3'd0,
      RG_DIAG  = 3'd1,
      RG_MODEM = 3'd2,
      RG_LED   = 3'd3,
      RG_SYS   = 3'd4,
      RG_AUX1  = 3'd5,
      RG_AUX2  = 3'd6,
      RG_NONE  = 3'd7
   } region_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSV  = 2'd3
   } size_e;

   typedef struct packed {
      logic cfg;
      logic diag;
      logic modem;
      logic led;
      logic sys;
      logic aux1;
      logic aux2;
   } hit_t;

   localparam int CFG_PFIE_BIT  = 3;
   localparam int AUX1_TC_BIT   = 1;
   localparam int AUX2_OFF_BIT  = 0;
   localparam int AUX2_CLR_BIT  = 1;
   localparam int AUX2_FLAG_BIT = 5;
   localparam int SYS_RST_BIT   = 0;
   localparam int SYS_STAT_BIT  = 1;

endpackage

// File: rtl/auxctl_sync.sv
module auxctl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("auxctl_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/auxctl_decode.sv
module auxctl_decode
   import auxctl_pkg::*;
#(
   parameter int REGION_W = 3,
   parameter int OFF_W    = 3
) (
   input  logic                sel,
   input  logic [REGION_W-1:0] region,
   input  logic [OFF_W-1:0]    off,
   input  logic [1:0]          size,
   output hit_t                hit,
   output logic                legal,
   output logic                sys_base
);
   generate
      if (REGION_W != 3) begin : g_bad_rw
         $error("auxctl_decode: REGION_W must be 3");
      end
      if (OFF_W < 3) begin : g_bad_ow
         $error("auxctl_decode: OFF_W must be at least 3");
      end
   endgenerate

   logic off_zero;
   logic word_align;
   assign off_zero   = (off == '0);
   assign word_align = (off[1:0] == 2'b00);

   always_comb begin
      hit      = '0;
      legal    = 1'b0;
      sys_base = 1'b0;
      if (sel) begin
         case (region)
            RG_CFG:   if (size == SZ_BYTE && off_zero) begin hit.cfg   = 1'b1; legal = 1'b1; end
            RG_DIAG:  if (size == SZ_BYTE && off_zero) begin hit.diag  = 1'b1; legal = 1'b1; end
            RG_MODEM: if (size == SZ_BYTE && off_zero) begin hit.modem = 1'b1; legal = 1'b1; end
            RG_AUX1:  if (size == SZ_BYTE && off_zero) begin hit.aux1  = 1'b1; legal = 1'b1; end
            RG_AUX2:  if (size == SZ_BYTE && off_zero) begin hit.aux2  = 1'b1; legal = 1'b1; end
            RG_LED:   if (size == SZ_HALF && off_zero) begin hit.led   = 1'b1; legal = 1'b1; end
            RG_SYS:   if (size == SZ_WORD && word_align) begin
                         hit.sys  = 1'b1;
                         legal    = 1'b1;
                         sys_base = off_zero;
                      end
            default:  ;
         endcase
      end
   end
endmodule

// File: rtl/auxctl_pwr.sv
module auxctl_pwr (
   input  logic clk,
   input  logic rst_n,
   input  logic pf_sync,
   input  logic pf_enable,
   input  logic aux2_we,
   input  logic wd_off,
   input  logic wd_clr,
   output logic flag_q,
   output logic off_q,
   output logic off_pulse
);
   logic pf_prev_q;
   logic pf_change;

   assign pf_change = (pf_sync != pf_prev_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pf_prev_q <= 1'b0;
         flag_q    <= 1'b0;
         off_q     <= 1'b0;
         off_pulse <= 1'b0;
      end else begin
         pf_prev_q <= pf_sync;
         off_pulse <= aux2_we & wd_off;
         if (aux2_we) begin
            off_q <= wd_off;
            if (wd_clr) flag_q <= 1'b0;
         end
         // an input edge in the same cycle as a write takes priority
         if (pf_change) flag_q <= pf_sync & pf_enable;
      end
   end
endmodule

// File: rtl/auxctl_top.sv
module auxctl_top
   import auxctl_pkg::*;
#(
   parameter  int REGION_W    = 3,
   parameter  int OFF_W       = 3,
   parameter  int BYTE_W      = 8,
   parameter  int LED_W       = 16,
   parameter  int WORD_W      = 32,
   parameter  int SYNC_STAGES = 2,
   localparam int ADDR_W      = REGION_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic              bus_err,
   input  logic              pwr_failing,
   output logic              pf_irq,
   output logic              tc_pulse,
   output logic              pwroff_req,
   output logic              sysrst_req
);
   generate
      if (BYTE_W < AUX2_FLAG_BIT + 1) begin : g_bad_bw
         $error("auxctl_top: BYTE_W too narrow for the aux2 flag");
      end
      if (LED_W > WORD_W || BYTE_W > LED_W) begin : g_bad_lw
         $error("auxctl_top: need BYTE_W <= LED_W <= WORD_W");
      end
   endgenerate

   localparam logic [BYTE_W-1:0] AUX1_KEEP = ~(BYTE_W'(1) << AUX1_TC_BIT);

   hit_t hit;
   logic legal, sys_base, pf_sync;
   logic flag_q, off_q, off_pulse;
   logic [BYTE_W-1:0] cfg_q, diag_q, modem_q, aux1_q;
   logic [LED_W-1:0]  led_q;
   logic              sys_stat_q;
   logic              we;

   auxctl_decode #(.REGION_W(REGION_W), .OFF_W(OFF_W)) u_dec (
      .sel      (bus_sel),
      .region   (bus_addr[ADDR_W-1:OFF_W]),
      .off      (bus_addr[OFF_W-1:0]),
      .size     (bus_size),
      .hit      (hit),
      .legal    (legal),
      .sys_base (sys_base)
   );

   auxctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pwr_failing),
      .q_sync  (pf_sync)
   );

   assign we = bus_sel & bus_wr & legal;

   auxctl_pwr u_pwr (
      .clk       (clk),
      .rst_n     (rst_n),
      .pf_sync   (pf_sync),
      .pf_enable (cfg_q[CFG_PFIE_BIT]),
      .aux2_we   (we & hit.aux2),
      .wd_off    (bus_wdata[AUX2_OFF_BIT]),
      .wd_clr    (bus_wdata[AUX2_CLR_BIT]),
      .flag_q    (flag_q),
      .off_q     (off_q),
      .off_pulse (off_pulse)
   );

   // registers cleared by reset, plus the pulse outputs
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q      <= '0;
         modem_q    <= '0;
         aux1_q     <= '0;
         tc_pulse   <= 1'b0;
         sysrst_req <= 1'b0;
         bus_err    <= 1'b0;
      end else begin
         tc_pulse   <= we & hit.aux1 & bus_wdata[AUX1_TC_BIT];
         sysrst_req <= we & hit.sys & sys_base & bus_wdata[SYS_RST_BIT];
         bus_err    <= bus_sel & ~legal;
         if (we & hit.cfg)   cfg_q   <= bus_wdata[BYTE_W-1:0];
         if (we & hit.modem) modem_q <= bus_wdata[BYTE_W-1:0];
         if (we & hit.aux1)  aux1_q  <= bus_wdata[BYTE_W-1:0] & AUX1_KEEP;
      end
   end

   // registers that keep their contents through reset
   always_ff @(posedge clk) begin
      if (we & hit.diag) diag_q <= bus_wdata[BYTE_W-1:0];
      if (we & hit.led)  led_q  <= bus_wdata[LED_W-1:0];
      if (we & hit.sys & sys_base & bus_wdata[SYS_RST_BIT]) sys_stat_q <= 1'b1;
   end

   assign pf_irq     = flag_q & cfg_q[CFG_PFIE_BIT];
   assign pwroff_req = off_pulse;

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr && legal) begin
         unique case (1'b1)
            hit.cfg:   bus_rdata[BYTE_W-1:0] = cfg_q;
            hit.diag:  bus_rdata[BYTE_W-1:0] = diag_q;
            hit.modem: bus_rdata[BYTE_W-1:0] = modem_q;
            hit.aux1:  bus_rdata[BYTE_W-1:0] = aux1_q;
            hit.led:   bus_rdata[LED_W-1:0]  = led_q;
            hit.aux2: begin
               bus_rdata[AUX2_OFF_BIT]  = off_q;
               bus_rdata[AUX2_FLAG_BIT] = flag_q;
            end
            hit.sys:   bus_rdata[SYS_STAT_BIT] = sys_base & sys_stat_q;
            default:   bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/auxctl_chk.sv
module auxctl_chk #(
   parameter int OFF_W  = 3,
   parameter int ADDR_W = 6,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        bus_size,
   input logic [WORD_W-1:0] bus_wdata,
   input logic [WORD_W-1:0] bus_rdata,
   input logic              bus_err,
   input logic              pf_irq,
   input logic              tc_pulse,
   input logic              pwroff_req,
   input logic              sysrst_req
);
   logic [ADDR_W-OFF_W-1:0] rg;
   logic                    off0;
   assign rg   = bus_addr[ADDR_W-1:OFF_W];
   assign off0 = (bus_addr[OFF_W-1:0] == '0);

   assert_irq_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_sel && bus_wr && rg == 3'd0 && bus_size == 2'd0 && off0 && !bus_wdata[3])
      |-> !pf_irq);

   assert_pwroff_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pwroff_req |-> $past(bus_sel && bus_wr && rg == 3'd6 && bus_size == 2'd0 && off0 && bus_wdata[0]));

   assert_tc_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tc_pulse |-> $past(bus_sel && bus_wr && rg == 3'd5 && bus_size == 2'd0 && off0 && bus_wdata[1]));

   assert_sysrst_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sysrst_req |-> $past(bus_sel && bus_wr && rg == 3'd4 && bus_size == 2'd2 && off0 && bus_wdata[0]));

   assert_err_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(bus_sel));

   assert_rsv_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_size == 2'd3) |-> (bus_rdata == '0));
endmodule

bind auxctl_top auxctl_chk #(.OFF_W(OFF_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/tb_auxctl_top.sv
module tb_auxctl_top;
   localparam int SYNC_STAGES = 3;
   localparam int PF_WAIT     = SYNC_STAGES + 3;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_sel, bus_wr;
   logic [5:0]  bus_addr;
   logic [1:0]  bus_size;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        bus_err, pwr_failing, pf_irq, tc_pulse, pwroff_req, sysrst_req;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   auxctl_top #(.SYNC_STAGES(SYNC_STAGES)) dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_err(bus_err), .pwr_failing(pwr_failing),
      .pf_irq(pf_irq), .tc_pulse(tc_pulse), .pwroff_req(pwroff_req),
      .sysrst_req(sysrst_req)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      bus_sel = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // returns at the negedge after the write edge: pulses are visible then
   task automatic wr(input logic [2:0] rg, input logic [2:0] off, input logic [1:0] sz, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = {rg, off}; bus_size = sz; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] rg, input logic [2:0] off, input logic [1:0] sz,
                     output logic [31:0] d, output logic e);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = {rg, off}; bus_size = sz;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
      e = bus_err;
   endtask

   task automatic t_reset_state();
      logic [31:0] d; logic e;
      rd(3'd0, 3'd0, 2'd0, d, e); chk("R7", "cfg after reset", d, 32'h0);
      rd(3'd5, 3'd0, 2'd0, d, e); chk("R7", "aux1 after reset", d, 32'h0);
      rd(3'd6, 3'd0, 2'd0, d, e); chk("R7", "aux2 after reset", d, 32'h0);
      rd(3'd2, 3'd0, 2'd0, d, e); chk("R7", "modem after reset", d, 32'h0);
      chk("R1", "irq after reset", {31'b0, pf_irq}, 32'h0);
      chk("R10", "pulses idle after reset", {28'b0, tc_pulse, pwroff_req, sysrst_req, bus_err}, 32'h0);
   endtask

   task automatic t_plain_rw();
      logic [31:0] d; logic e;
      wr(3'd0, 3'd0, 2'd0, 32'h0000_0055);
      wr(3'd1, 3'd0, 2'd0, 32'hFFFF_FFA5);
      wr(3'd2, 3'd0, 2'd0, 32'h0000_003C);
      wr(3'd3, 3'd0, 2'd1, 32'h1234_BEEF);
      rd(3'd0, 3'd0, 2'd0, d, e); chk("R9", "cfg readback", d, 32'h55);
      rd(3'd1, 3'd0, 2'd0, d, e); chk("R9", "diag readback", d, 32'hA5);
      rd(3'd2, 3'd0, 2'd0, d, e); chk("R9", "modem readback", d, 32'h3C);
      rd(3'd3, 3'd0, 2'd1, d, e); chk("R9", "led readback", d, 32'hBEEF);
      chk("R8", "no err on legal read", {31'b0, e}, 32'h0);
   endtask

   task automatic t_aux1();
      logic [31:0] d; logic e;
      wr(3'd5, 3'd0, 2'd0, 32'h0000_00FF);
      chk("R5", "tc pulse on bit1", {31'b0, tc_pulse}, 32'h1);
      @(negedge clk);
      chk("R10", "tc pulse drops", {31'b0, tc_pulse}, 32'h0);
      rd(3'd5, 3'd0, 2'd0, d, e); chk("R5", "aux1 bit1 not stored", d, 32'hFD);
      wr(3'd5, 3'd0, 2'd0, 32'h0000_0001);
      chk("R5", "no tc pulse without bit1", {31'b0, tc_pulse}, 32'h0);
      rd(3'd5, 3'd0, 2'd0, d, e); chk("R5", "aux1 plain store", d, 32'h01);
   endtask

   task automatic t_pwrfail();
      logic [31:0] d; logic e;
      wr(3'd0, 3'd0, 2'd0, 32'h08);
      pwr_failing = 1'b1;
      repeat (PF_WAIT) @(negedge clk);
      chk("R1", "irq with flag and enable", {31'b0, pf_irq}, 32'h1);
      rd(3'd6, 3'd0, 2'd0, d, e); chk("R2", "flag latched", d, 32'h20);
      wr(3'd0, 3'd0, 2'd0, 32'h00);
      chk("R1", "irq masked by enable", {31'b0, pf_irq}, 32'h0);
      rd(3'd6, 3'd0, 2'd0, d, e); chk("R2", "flag kept when enable cleared", d, 32'h20);
      wr(3'd0, 3'd0, 2'd0, 32'h08);
      chk("R1", "irq back on", {31'b0, pf_irq}, 32'h1);
      wr(3'd6, 3'd0, 2'd0, 32'hFC);
      rd(3'd6, 3'd0, 2'd0, d, e); chk("R3", "only bits 0,1 writable", d, 32'h20);
      wr(3'd6, 3'd0, 2'd0, 32'h02);
      rd(3'd6, 3'd0, 2'd0, d, e); chk("R3", "clear bit removes flag", d, 32'h00);
      chk("R1", "irq after clear", {31'b0, pf_irq}, 32'h0);
      pwr_failing = 1'b0;
      repeat (PF_WAIT) @(negedge clk);
      wr(3'd0, 3'd0, 2'd0, 32'h00);
      pwr_failing = 1'b1;
      repeat (PF_WAIT) @(negedge clk);
      rd(3'd6, 3'd0, 2'd0, d, e); chk("R2", "no latch while disabled", d, 32'h00);
      pwr_failing = 1'b0;
      repeat (PF_WAIT) @(negedge clk);
   endtask

   task automatic t_pwroff();
      logic [31:0] d; logic e;
      wr(3'd6, 3'd0, 2'd0, 32'h01);
      chk("R4", "power-off pulse", {31'b0, pwroff_req}, 32'h1);
      @(negedge clk);
      chk("R10", "power-off pulse drops", {31'b0, pwroff_req}, 32'h0);
      rd(3'd6, 3'd0, 2'd0, d, e); chk("R3", "aux2 bit0 readback", d, 32'h01);
      wr(3'd6, 3'd0, 2'd0, 32'h00);
      chk("R4", "no power-off pulse", {31'b0, pwroff_req}, 32'h0);
   endtask

   task automatic t_sysctl();
      logic [31:0] d; logic e;
      wr(3'd4, 3'd0, 2'd2, 32'hFFFF_FFFE);
      chk("R6", "no reset with bit0 clear", {31'b0, sysrst_req}, 32'h0);
      wr(3'd4, 3'd4, 2'd2, 32'h1);
      chk("R6", "no reset at offset 4", {31'b0, sysrst_req}, 32'h0);
      rd(3'd4, 3'd4, 2'd2, d, e); chk("R6", "offset 4 reads zero", d, 32'h0);
      wr(3'd4, 3'd0, 2'd2, 32'h1);
      chk("R6", "reset request pulse", {31'b0, sysrst_req}, 32'h1);
      @(negedge clk);
      chk("R10", "reset pulse drops", {31'b0, sysrst_req}, 32'h0);
      rd(3'd4, 3'd0, 2'd2, d, e); chk("R6", "status reads 2", d, 32'h2);
   endtask

   task automatic t_size();
      logic [31:0] d; logic e;
      wr(3'd0, 3'd0, 2'd2, 32'h08);
      chk("R8", "err after word write to byte reg", {31'b0, bus_err}, 32'h1);
      @(negedge clk);
      chk("R8", "err drops", {31'b0, bus_err}, 32'h0);
      rd(3'd0, 3'd0, 2'd0, d, e); chk("R8", "bad write ignored", d, 32'h00);
      rd(3'd1, 3'd0, 2'd1, d, e);
      chk("R8", "bad read returns zero", d, 32'h0);
      chk("R8", "err after bad read", {31'b0, e}, 32'h1);
      rd(3'd3, 3'd0, 2'd0, d, e); chk("R8", "byte read of led is zero", d, 32'h0);
      wr(3'd2, 3'd1, 2'd0, 32'hFF);
      rd(3'd2, 3'd0, 2'd0, d, e); chk("R8", "nonzero offset write ignored", d, 32'h3C);
      rd(3'd7, 3'd0, 2'd0, d, e);
      chk("R8", "unused region err", {31'b0, e}, 32'h1);
   endtask

   task automatic t_sticky();
      logic [31:0] d; logic e;
      wr(3'd1, 3'd0, 2'd0, 32'h96);
      wr(3'd0, 3'd0, 2'd0, 32'h08);
      do_reset();
      rd(3'd1, 3'd0, 2'd0, d, e); chk("R7", "diag survives reset", d, 32'h96);
      rd(3'd4, 3'd0, 2'd2, d, e); chk("R7", "sysctl survives reset", d, 32'h2);
      rd(3'd3, 3'd0, 2'd1, d, e); chk("R7", "led survives reset", d, 32'hBEEF);
      rd(3'd0, 3'd0, 2'd0, d, e); chk("R7", "cfg cleared", d, 32'h0);
      rd(3'd5, 3'd0, 2'd0, d, e); chk("R7", "aux1 cleared", d, 32'h0);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
      bus_size = '0; bus_wdata = '0; pwr_failing = 1'b0;
      do_reset();
      t_reset_state();
      t_plain_rw();
      t_aux1();
      t_pwrfail();
      t_pwroff();
      t_sysctl();
      t_size();
      t_sticky();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule